// File: doc/BRIEF.md
# Serial Debug Command Executor

This block sits behind the shift register of a serial debug link. Each byte that arrives comes with a one-cycle valid strobe. The executor reads the first byte as a command. For commands that need an operand, it takes the next valid byte as that operand. It then carries out the command against three targets:

- a 16-bit address pointer;
- a byte-wide data-space write port;
- a 64-entry I/O register port.

A read command fetches one I/O register in the same cycle that the command arrives. The executor then holds that byte for the link until the link marks it as taken.

Command encodings:

| Code | Meaning |
|---|---|
| 0x60 | Store the next byte at the pointer address; the pointer stays as it is. |
| 0x64 | Store the next byte at the pointer address, then add one to the pointer. |
| 0x68 | Put the next byte into the pointer's low byte. |
| 0x69 | Put the next byte into the pointer's high byte. |
| Bit 4 set | Direct I/O access. Bit 7 picks the direction: 0 reads, 1 writes. The register number is opcode bits 6:5 on top of bits 3:0. |

Host software must set the pointer before it issues any store.

Top module: `dbg_cmd_exec`

## Requirements
- R1: A synchronous reset sets the pointer to 0x0000 and leaves the executor waiting for a command with `tx_valid` low; a command in progress is abandoned.
- R2: After 0x60 and a data byte, `ds_we` pulses for exactly the data byte's cycle with `ds_addr` equal to the pointer and `ds_wdata` equal to the byte; the pointer (always visible on `ds_addr`) is unchanged afterwards.
- R3: After 0x64 and a data byte, the store uses the pointer value from before the increment, and the pointer is one higher from the next cycle on.
- R4: The pointer increment wraps from 0xFFFF to 0x0000.
- R5: 0x68 followed by a byte replaces pointer bits 7:0; 0x69 followed by a byte replaces bits 15:8; the other byte is kept.
- R6: An opcode with bit 4 = 1 and bit 7 = 0 raises `io_re` in its own cycle with `io_addr` = {op[6:5], op[3:0]}. From the next cycle, `tx_valid` is high and `tx_byte` holds the value `io_rdata` had in that cycle. Both stay stable until a cycle with `tx_taken` high, after which `tx_valid` falls.
- R7: An opcode with bit 4 = 1 and bit 7 = 1, followed by a data byte, pulses `io_we` in the data byte's cycle with `io_addr` = {op[6:5], op[3:0]} and `io_wdata` = the byte.
- R8: A byte that matches no encoding produces no strobe, and the following byte is decoded as a new opcode.
- R9: At most one of `ds_we`, `io_we` and `io_re` is high in any cycle, and while an operand is awaited, cycles without `rx_valid` cause no strobe.
- R10: While read-out data is held, arriving bytes are ignored, including one that arrives in the same cycle as `tx_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte (opcode or operand) |
| tx_taken | input | 1 | The link has consumed the read-out byte |
| tx_valid | output | 1 | Read-out byte is valid |
| tx_byte | output | 8 | Read-out byte |
| ds_we | output | 1 | Data-space write strobe |
| ds_addr | output | 16 | Data-space address (current pointer) |
| ds_wdata | output | 8 | Data-space write data |
| io_we | output | 1 | I/O register write strobe |
| io_re | output | 1 | I/O register read request |
| io_addr | output | 6 | I/O register number |
| io_wdata | output | 8 | I/O register write data |
| io_rdata | input | 8 | I/O register read data, same cycle as `io_re` |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a release and a new byte. The link can release the held read-out byte in the cycle that a new byte arrives. The bench drives `tx_taken` and `rx_valid` together. It then checks that the byte was dropped: no strobe follows, and the next byte is decoded as an opcode.

The second pair is a store and an increment. A post-increment store writes memory and advances the pointer on the same edge. The bench checks that the write address is the old pointer and that `ds_addr` shows the new value one cycle later, including at the 0xFFFF wrap.

A behavioural model in the bench is compared against every output on every cycle, during both directed sequences and a weighted random byte stream.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam int IO_AW  = 6;

    localparam logic [BYTE_W-1:0] OPC_ST_KEEP = 8'h60;
    localparam logic [BYTE_W-1:0] OPC_ST_INC  = 8'h64;
    localparam logic [6:0]        OPC_PTR_TOP = 7'b0110100;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RESP
    } exec_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ST,
        OP_ST_INC,
        OP_PTR_LD,
        OP_IO_RD,
        OP_IO_WR
    } op_kind_e;

endpackage

// File: rtl/dbg_opcode_decode.sv
module dbg_opcode_decode
    import dbg_cmd_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output op_kind_e          kind,
    output logic              sel_hi,
    output logic [IO_AW-1:0]  io_addr
);

    always_comb begin
        kind = OP_NONE;
        if (op[4]) begin
            kind = op[7] ? OP_IO_WR : OP_IO_RD;
        end else if (op == OPC_ST_KEEP) begin
            kind = OP_ST;
        end else if (op == OPC_ST_INC) begin
            kind = OP_ST_INC;
        end else if (op[7:1] == OPC_PTR_TOP) begin
            kind = OP_PTR_LD;
        end
    end

    assign sel_hi  = op[0];
    // the register number is split across the opcode around the fixed bit 4
    assign io_addr = {op[6:5], op[3:0]};

endmodule

// File: rtl/dbg_ptr_reg.sv
module dbg_ptr_reg
    import dbg_cmd_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [SEL_W-1:0] load_sel,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic             inc_en,
    output logic [PTR_W-1:0] ptr
);

    localparam int NB    = PTR_W / BYTE_W;
    localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1;

    logic [PTR_W-1:0] ptr_d, ptr_q, loaded_d;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign loaded_d[g*BYTE_W +: BYTE_W] =
            (load_en && (load_sel == SEL_W'(g))) ? load_byte
                                                  : ptr_q[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        ptr_d = loaded_d;
        if (inc_en) begin
            ptr_d = ptr_q + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr = ptr_q;

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (inc_en && ptr_q == {PTR_W{1'b1}}) |=> (ptr_q == '0)) // R4
        else $error("pointer did not wrap to zero");

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc_en && !$past(rst)) |=> (ptr_q == $past(ptr_q) + PTR_W'(1))) // R3
        else $error("pointer did not advance by one");

endmodule

// File: rtl/dbg_cmd_exec.sv
module dbg_cmd_exec
    import dbg_cmd_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_taken,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              ds_we,
    output logic [PTR_W-1:0]  ds_addr,
    output logic [BYTE_W-1:0] ds_wdata,
    output logic              io_we,
    output logic              io_re,
    output logic [IO_AW-1:0]  io_addr,
    output logic [BYTE_W-1:0] io_wdata,
    input  logic [BYTE_W-1:0] io_rdata
);

    localparam int NB    = PTR_W / BYTE_W;
    localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1;

    typedef struct packed {
        exec_state_e       st;
        op_kind_e          kind;
        logic              sel;
        logic [IO_AW-1:0]  ioa;
        logic [BYTE_W-1:0] tx;
    } exec_regs_t;

    exec_regs_t r_d, r_q;

    op_kind_e          dec_kind;
    logic              dec_sel;
    logic [IO_AW-1:0]  dec_ioa;
    logic              ptr_ld, ptr_inc;
    logic [PTR_W-1:0]  ptr;

    dbg_opcode_decode u_dec (
        .op      (rx_byte),
        .kind    (dec_kind),
        .sel_hi  (dec_sel),
        .io_addr (dec_ioa)
    );

    dbg_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load_en   (ptr_ld),
        .load_sel  (SEL_W'(r_q.sel)),
        .load_byte (rx_byte),
        .inc_en    (ptr_inc),
        .ptr       (ptr)
    );

    always_comb begin
        r_d      = r_q;
        ds_we    = 1'b0;
        io_we    = 1'b0;
        io_re    = 1'b0;
        io_addr  = r_q.ioa;
        ptr_ld   = 1'b0;
        ptr_inc  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (rx_valid) begin
                    if (dec_kind == OP_IO_RD) begin
                        io_re   = 1'b1;
                        io_addr = dec_ioa;
                        r_d.tx  = io_rdata;
                        r_d.st  = ST_RESP;
                    end else if (dec_kind != OP_NONE) begin
                        r_d.st   = ST_WAIT;
                        r_d.kind = dec_kind;
                        r_d.sel  = dec_sel;
                        r_d.ioa  = dec_ioa;
                    end
                end
            end
            ST_WAIT: begin
                if (rx_valid) begin
                    r_d.st = ST_IDLE;
                    case (r_q.kind)
                        OP_ST:     ds_we = 1'b1;
                        OP_ST_INC: begin
                            ds_we   = 1'b1;
                            ptr_inc = 1'b1;
                        end
                        OP_PTR_LD: ptr_ld = 1'b1;
                        OP_IO_WR:  io_we  = 1'b1;
                        default:   ;
                    endcase
                end
            end
            ST_RESP: begin
                if (tx_taken) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, kind: OP_NONE, sel: 1'b0, ioa: '0, tx: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ds_addr  = ptr;
    assign ds_wdata = rx_byte;
    assign io_wdata = rx_byte;
    assign tx_valid = (r_q.st == ST_RESP);
    assign tx_byte  = r_q.tx;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ds_we, io_we, io_re})) // R9
        else $error("more than one port strobe");

    AST_NO_IDLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> !(ds_we || io_we || io_re)) // R9
        else $error("strobe without a received byte");

    AST_KEEP_PTR: assert property (@(posedge clk) disable iff (rst)
        (ds_we && !ptr_inc) |=> $stable(ds_addr)) // R2
        else $error("plain store moved the pointer");

    AST_READ_RESP: assert property (@(posedge clk) disable iff (rst)
        io_re |=> (tx_valid && tx_byte == $past(io_rdata))) // R6
        else $error("read data not presented");

    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_taken) |=> (tx_valid && $stable(tx_byte))) // R6
        else $error("read-out byte not held");

    AST_RESP_MUTE: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !(ds_we || io_we || io_re)) // R10
        else $error("byte acted on during read-out");

    AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_IDLE && rx_valid && dec_kind == OP_NONE)
            |=> (r_q.st == ST_IDLE)) // R8
        else $error("unmatched opcode left idle");

endmodule

// File: tb/sim_dbg_cmd_exec.sv
module sim_dbg_cmd_exec;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       tx_taken;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       ds_we;
    logic [15:0] ds_addr;
    logic [7:0] ds_wdata;
    logic       io_we;
    logic       io_re;
    logic [5:0] io_addr;
    logic [7:0] io_wdata;
    logic [7:0] io_rdata;

    logic [7:0] io_regs [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_cmd_exec u0 (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_taken(tx_taken), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
        .io_we(io_we), .io_re(io_re), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    assign io_rdata = io_regs[io_addr];

    always @(posedge clk) begin
        if (io_we) io_regs[io_addr] <= io_wdata;
    end

    // behavioural reference model: 0 idle, 1 awaiting operand, 2 holding read-out
    int          m_st;
    int          m_kind;   // 0 store, 1 store+inc, 2 pointer load, 4 io write
    logic        m_sel;
    logic [15:0] m_ptr;
    logic [5:0]  m_ioa;
    logic [7:0]  m_tx;
    logic [7:0]  m_io [64];

    int    n_chk  = 0;
    int    n_fail = 0;
    string phase  = "R1";

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic v, input logic [7:0] b,
                        input logic t);
        logic e_ds, e_iow, e_ior;
        @(negedge clk);
        rst = r; rx_valid = v; rx_byte = b; tx_taken = t;
        #(CLK_PERIOD/4);
        if (!r) begin
            e_ds  = (m_st == 1) && v && (m_kind == 0 || m_kind == 1);
            e_iow = (m_st == 1) && v && (m_kind == 4);
            e_ior = (m_st == 0) && v && b[4] && !b[7];
            check(phase, "ds_addr", 16'(ds_addr), m_ptr);
            check(phase, "ds_we", 16'(ds_we), 16'(e_ds));
            check(phase, "io_we", 16'(io_we), 16'(e_iow));
            check(phase, "io_re", 16'(io_re), 16'(e_ior));
            check(phase, "tx_valid", 16'(tx_valid), 16'(m_st == 2));
            if (e_ds)  check(phase, "ds_wdata", 16'(ds_wdata), 16'(b));
            if (e_iow) begin
                check(phase, "io_addr wr", 16'(io_addr), 16'(m_ioa));
                check(phase, "io_wdata", 16'(io_wdata), 16'(b));
            end
            if (e_ior) check(phase, "io_addr rd", 16'(io_addr),
                             16'({b[6:5], b[3:0]}));
            if (m_st == 2) check(phase, "tx_byte", 16'(tx_byte), 16'(m_tx));
        end
        if (r) begin
            m_st = 0; m_ptr = '0;
        end else begin
            case (m_st)
                0: if (v) begin
                    if (b[4] && !b[7]) begin
                        m_tx = m_io[{b[6:5], b[3:0]}]; m_st = 2;
                    end else if (b[4]) begin
                        m_kind = 4; m_ioa = {b[6:5], b[3:0]}; m_st = 1;
                    end else if (b == 8'h60) begin
                        m_kind = 0; m_st = 1;
                    end else if (b == 8'h64) begin
                        m_kind = 1; m_st = 1;
                    end else if (b[7:1] == 7'b0110100) begin
                        m_kind = 2; m_sel = b[0]; m_st = 1;
                    end
                end
                1: if (v) begin
                    m_st = 0;
                    if (m_kind == 1) m_ptr = m_ptr + 16'd1;
                    if (m_kind == 2) begin
                        if (m_sel) m_ptr[15:8] = b; else m_ptr[7:0] = b;
                    end
                    if (m_kind == 4) m_io[m_ioa] = b;
                end
                default: if (t) m_st = 0;
            endcase
        end
    endtask

    task automatic send(input logic [7:0] b);
        step(1'b0, 1'b1, b, 1'b0);
    endtask

    task automatic gap();
        step(1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            io_regs[i] = 8'(i * 3 + 7);
            m_io[i]    = 8'(i * 3 + 7);
        end
        m_st = 0; m_kind = 0; m_sel = 0; m_ptr = '0; m_ioa = '0; m_tx = '0;
        rst = 1; rx_valid = 0; rx_byte = 0; tx_taken = 0;

        // R1: reset state, then a store lands at address zero
        step(1'b1, 1'b0, 8'h00, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        phase = "R1";
        gap();
        send(8'h60); send(8'h3C);

        // R5: pointer bytes loaded separately
        phase = "R5";
        send(8'h68); send(8'h34); gap();
        send(8'h69); send(8'h12); gap();

        // R2: plain store keeps pointer; R9: gaps while waiting
        phase = "R2";
        send(8'h60); gap(); gap(); send(8'hAA);
        send(8'h60); send(8'hBB); gap();

        // R3: post-increment store
        phase = "R3";
        send(8'h64); send(8'hCC);
        send(8'h60); send(8'hDD);

        // R4: wrap from 0xFFFF
        phase = "R4";
        send(8'h68); send(8'hFF); send(8'h69); send(8'hFF);
        send(8'h64); send(8'h11);
        send(8'h60); send(8'h22);

        // R7: io write to register 0x2A (opcode 1_10_1_1010)
        phase = "R7";
        send(8'hDA); send(8'h5A); gap();

        // R6: io read of register 0x2A, held three cycles then taken
        phase = "R6";
        send(8'h5A); gap(); gap(); gap();
        step(1'b0, 1'b0, 8'h00, 1'b1); gap();

        // R8: unmatched bytes, then a store decoded normally
        phase = "R8";
        send(8'h00); send(8'h61); send(8'h6A); send(8'hEF & 8'hE0);
        send(8'h60); send(8'h77);

        // R10: bytes during read-out and together with tx_taken are dropped
        phase = "R10";
        send(8'h13); send(8'h60); send(8'h68);
        step(1'b0, 1'b1, 8'h64, 1'b1);
        send(8'h69); send(8'h00); gap();

        // R1: reset while an operand is awaited
        phase = "R1";
        send(8'h64);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        send(8'h55); gap();

        // R9: weighted random byte stream
        phase = "R9";
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] b;
            int sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0: b = 8'h60;
                1: b = 8'h64;
                2: b = 8'h68 | 8'($urandom_range(0, 1));
                3: b = 8'h10 | 8'($urandom_range(0, 255) & 8'hEF);
                default: b = 8'($urandom_range(0, 255));
            endcase
            step(1'b0, 1'($urandom_range(0, 2) != 0), b,
                 1'($urandom_range(0, 2) == 0));
        end

        finish_run();
    end

endmodule